// File: doc/BRIEF.md
# Grouped Port Falling-Edge Interrupt

This block raises one shared interrupt request from a group of general-purpose pins on three 4-bit ports (A, B and C). It combines the group into one level: a pin only takes part when it is in the group and its direction bit makes it an input. Every other pin counts as high. The request flag is set when that combined level drops from all-high to not-all-high. A static parameter chooses which pins form the group.

Because detection works on the combined level, one pin going low masks all later falls until every participating pin is high again. The pins pass through a synchronizer before detection. Software sees a request flag and an enable flag. It clears the request by writing 0 and sets the enable through a small write port. The interrupt output is the request gated by the enable.

Top module: `grouped_edge_irq`

## Requirements
- R1: After reset, `req_flag`, `en_flag` and `irq` are 0. A pin already low at reset raises no request.
- R2: With `GROUP_SEL` = 0, the group is port B bits 0–3 and port C bits 0–3. Port A never raises a request.
- R3: With `GROUP_SEL` = 1, the group is port A bits 1–3, port B bits 0–3 and port C bit 0. Port A bit 0 and port C bits 1–3 never raise a request.
- R4: A direction bit of 1 makes that pin an output. An output pin is treated as high and cannot raise a request.
- R5: When the combined level of the participating pins falls from 1 to 0, `req_flag` becomes 1. This is visible after the third rising clock edge following the pin change (two synchronizer stages plus the flag register).
- R6: While any participating pin is still low, a further pin falling raises no new request. Detection re-arms only after all participating pins are high again.
- R7: A pin rising never sets `req_flag`.
- R8: Writing with `cfg_sel` = 1 targets the request register, and bit 0 of `cfg_wdata` is the request bit. Writing 0 there clears `req_flag`. Writing 1 there leaves the flag unchanged.
- R9: If a hardware set and a software clear of the request fall in the same cycle, the flag ends up 1.
- R10: Writing with `cfg_sel` = 0 loads `en_flag` from bit 0 of `cfg_wdata`. `irq` is `req_flag` AND `en_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pa_pin | input | 4 | Port A pin levels |
| pb_pin | input | 4 | Port B pin levels |
| pc_pin | input | 4 | Port C pin levels |
| pa_dir | input | 4 | Port A direction, 1 = output |
| pb_dir | input | 4 | Port B direction, 1 = output |
| pc_dir | input | 4 | Port C direction, 1 = output |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = enable register, 1 = request register |
| cfg_wdata | input | 4 | Write data; only bit 0 is used |
| req_flag | output | 1 | Port interrupt request flag |
| en_flag | output | 1 | Port interrupt enable flag |
| irq | output | 1 | Gated interrupt output |

## Verification
A vector table drives one pin low at a time on two instances, one per group option. Each case covers a pin that belongs to only one of the two groups, to both, or to neither, so the results tell the two member lists apart. The table also has a group pin set as an output while it goes low, which separates direction gating from group membership.

Directed sequences then check the following:
- A second fall while a first pin is still low gives no request, and a fall after all pins are high again gives one.
- Raising low pins gives no request.
- A clear write that lands on the same edge as a set leaves the flag at 1.
- The enable flag gates the output.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

   typedef enum logic {
      CFG_ENABLE  = 1'b0,
      CFG_REQUEST = 1'b1
   } cfg_sel_e;

   // Group membership of one port, per group option and port index (0=A,1=B,2=C)
   function automatic logic [3:0] member_mask(input int sel, input int port);
      logic [3:0] m;
      m = 4'b0000;
      if (sel == 0) begin
         if (port == 1 || port == 2) m = 4'b1111;
      end else begin
         if (port == 0) m = 4'b1110;
         if (port == 1) m = 4'b1111;
         if (port == 2) m = 4'b0001;
      end
      return m;
   endfunction

endpackage

// File: rtl/grp_irq_sync.sv
module grp_irq_sync #(
   parameter int WIDTH  = 12,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (STAGES < 2) $error("grp_irq_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("grp_irq_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/grp_irq_combine.sv
module grp_irq_combine
   import grp_irq_pkg::*;
#(
   parameter int PORT_W    = 4,
   parameter int GROUP_SEL = 0
) (
   input  logic [3*PORT_W-1:0] pins,
   input  logic [3*PORT_W-1:0] dirs,
   output logic                level
);
   localparam int ALL_W = 3 * PORT_W;

   initial begin
      if (PORT_W != 4) $error("grp_irq_combine: PORT_W must be 4");
      if (GROUP_SEL != 0 && GROUP_SEL != 1) $error("grp_irq_combine: GROUP_SEL must be 0 or 1");
   end

   logic [ALL_W-1:0] member;
   logic [ALL_W-1:0] active;
   logic [ALL_W-1:0] forced;

   generate
      if (GROUP_SEL == 0) begin : g_opt0
         assign member = {member_mask(0, 2), member_mask(0, 1), member_mask(0, 0)};
      end else begin : g_opt1
         assign member = {member_mask(1, 2), member_mask(1, 1), member_mask(1, 0)};
      end
   endgenerate

   always_comb begin
      active = member & ~dirs;
      forced = pins | ~active;
      level  = &forced;
   end
endmodule

// File: rtl/grp_irq_edge.sv
module grp_irq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic fall
);
   logic level_q;

   // Held low out of reset so no request is raised before the group is seen high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign fall = level_q & ~level;
endmodule

// File: rtl/grp_irq_flags.sv
module grp_irq_flags
   import grp_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hw_set,
   input  logic       cfg_we,
   input  logic       cfg_sel,
   input  logic [3:0] cfg_wdata,
   output logic       req_q,
   output logic       en_q
);
   logic sw_clear;
   logic en_write;

   always_comb begin
      sw_clear = cfg_we && (cfg_sel == CFG_REQUEST) && !cfg_wdata[0];
      en_write = cfg_we && (cfg_sel == CFG_ENABLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         if (hw_set)        req_q <= 1'b1;
         else if (sw_clear) req_q <= 1'b0;
         if (en_write)      en_q  <= cfg_wdata[0];
      end
   end
endmodule

// File: rtl/grouped_edge_irq.sv
module grouped_edge_irq #(
   parameter int PORT_W      = 4,
   parameter int GROUP_SEL   = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] pa_pin,
   input  logic [PORT_W-1:0] pb_pin,
   input  logic [PORT_W-1:0] pc_pin,
   input  logic [PORT_W-1:0] pa_dir,
   input  logic [PORT_W-1:0] pb_dir,
   input  logic [PORT_W-1:0] pc_dir,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [3:0]        cfg_wdata,
   output logic              req_flag,
   output logic              en_flag,
   output logic              irq
);
   localparam int ALL_W = 3 * PORT_W;

   logic [ALL_W-1:0] pins_sync;
   logic             grp_level;
   logic             grp_fall;

   grp_irq_sync #(.WIDTH(ALL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pc_pin, pb_pin, pa_pin}),
      .q     (pins_sync)
   );

   grp_irq_combine #(.PORT_W(PORT_W), .GROUP_SEL(GROUP_SEL)) u_comb (
      .pins  (pins_sync),
      .dirs  ({pc_dir, pb_dir, pa_dir}),
      .level (grp_level)
   );

   grp_irq_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (grp_level),
      .fall  (grp_fall)
   );

   grp_irq_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_set    (grp_fall),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .req_q     (req_flag),
      .en_q      (en_flag)
   );

   assign irq = req_flag & en_flag;
endmodule

// File: rtl/grouped_edge_irq_chk.sv
module grouped_edge_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       grp_level,
   input logic       grp_fall,
   input logic       cfg_we,
   input logic       cfg_sel,
   input logic [3:0] cfg_wdata,
   input logic       req_flag,
   input logic       en_flag,
   input logic       irq
);
   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (req_flag && en_flag));

   // R5
   req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_flag) |-> $past(!grp_level));

   // R8
   req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_flag) |-> $past(cfg_we && cfg_sel && !cfg_wdata[0]));

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_fall && cfg_we && cfg_sel && !cfg_wdata[0]) |=> req_flag);

   // R10
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_sel) |=> (en_flag == $past(cfg_wdata[0])));

   // R7
   no_rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_fall |-> !grp_level);
endmodule

bind grouped_edge_irq grouped_edge_irq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .grp_level (grp_level),
   .grp_fall  (grp_fall),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .cfg_wdata (cfg_wdata),
   .req_flag  (req_flag),
   .en_flag   (en_flag),
   .irq       (irq)
);

// File: tb/grouped_edge_irq_test.sv
`timescale 1ns/1ps
module grouped_edge_irq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pa_pin = 4'hF, pb_pin = 4'hF, pc_pin = 4'hF;
   logic [3:0] pa_dir = 4'h0, pb_dir = 4'h0, pc_dir = 4'h0;
   logic       cfg_we = 1'b0;
   logic       cfg_sel = 1'b0;
   logic [3:0] cfg_wdata = 4'h0;
   logic       req0, en0, irq0, req1, en1, irq1;
   int         n_tests = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   grouped_edge_irq #(.GROUP_SEL(0)) uut (
      .clk(clk), .rst_n(rst_n), .pa_pin(pa_pin), .pb_pin(pb_pin), .pc_pin(pc_pin),
      .pa_dir(pa_dir), .pb_dir(pb_dir), .pc_dir(pc_dir), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_flag(req0), .en_flag(en0), .irq(irq0));

   grouped_edge_irq #(.GROUP_SEL(1)) uut_alt (
      .clk(clk), .rst_n(rst_n), .pa_pin(pa_pin), .pb_pin(pb_pin), .pc_pin(pc_pin),
      .pa_dir(pa_dir), .pb_dir(pb_dir), .pc_dir(pc_dir), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_flag(req1), .en_flag(en1), .irq(irq1));

   // {pa, pb, pc, pb_dir, expect option 0, expect option 1}
   localparam logic [17:0] VEC [8] = '{
      {4'hF, 4'hE, 4'hF, 4'h0, 1'b1, 1'b1},
      {4'hE, 4'hF, 4'hF, 4'h0, 1'b0, 1'b0},
      {4'h7, 4'hF, 4'hF, 4'h0, 1'b0, 1'b1},
      {4'hF, 4'hF, 4'h7, 4'h0, 1'b1, 1'b0},
      {4'hF, 4'hB, 4'hF, 4'h4, 1'b0, 1'b0},
      {4'hF, 4'hF, 4'hE, 4'h0, 1'b1, 1'b1},
      {4'hD, 4'hF, 4'hF, 4'h0, 1'b0, 1'b1},
      {4'hF, 4'hF, 4'hF, 4'h0, 1'b0, 1'b0}
   };

   task automatic check(input logic got, input logic exp, input string req, input string what);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [3:0] data);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0; cfg_wdata = 4'h0;
   endtask

   task automatic all_high();
      pa_pin = 4'hF; pb_pin = 4'hF; pc_pin = 4'hF;
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: pins low while in reset must not yield a request afterwards
      pb_pin = 4'h0;
      cycles(3);
      rst_n = 1'b1;
      cycles(5);
      check(req0, 1'b0, "R1", "req after reset");
      check(en0, 1'b0, "R1", "en after reset");
      check(irq0, 1'b0, "R1", "irq after reset");

      // Table: R2 R3 R4 R5
      foreach (VEC[k]) begin
         all_high();
         pb_dir = VEC[k][5:2];
         cycles(4);
         wr(1'b1, 4'h0);
         cycles(1);
         pa_pin = VEC[k][17:14];
         pb_pin = VEC[k][13:10];
         pc_pin = VEC[k][9:6];
         cycles(4);
         check(req0, VEC[k][1], "R2/R4/R5", $sformatf("option0 vector %0d", k));
         check(req1, VEC[k][0], "R3/R4/R5", $sformatf("option1 vector %0d", k));
      end
      pb_dir = 4'h0;

      // R5: exact latency, third edge after change
      all_high(); cycles(4); wr(1'b1, 4'h0); cycles(1);
      pb_pin = 4'hE;
      cycles(2);
      check(req0, 1'b0, "R5", "req before third edge");
      cycles(1);
      check(req0, 1'b1, "R5", "req at third edge");

      // R6: second fall while first pin still low
      wr(1'b1, 4'h0);
      pb_pin = 4'hC;
      cycles(5);
      check(req0, 1'b0, "R6", "no re-trigger while group low");
      all_high(); cycles(4);
      pc_pin = 4'hB;
      cycles(4);
      check(req0, 1'b1, "R6", "re-armed after all high");

      // R7: rising pins give no request
      pb_pin = 4'h0; cycles(4);
      wr(1'b1, 4'h0); cycles(1);
      all_high(); cycles(5);
      check(req0, 1'b0, "R7", "no request on rise");

      // R8: writing 1 to the request bit does not set it
      wr(1'b1, 4'h1); cycles(1);
      check(req0, 1'b0, "R8", "write 1 ignored");

      // R9: clear on the same edge as the set
      pb_pin = 4'h7;
      cycles(2);
      cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 4'h0;
      @(negedge clk);
      cfg_we = 1'b0;
      check(req0, 1'b1, "R9", "set wins over clear");

      // R10: enable gating
      check(irq0, 1'b0, "R10", "irq masked by enable");
      wr(1'b0, 4'h1);
      check(en0, 1'b1, "R10", "enable loaded");
      check(irq0, 1'b1, "R10", "irq when enabled");
      wr(1'b0, 4'hE);
      check(irq0, 1'b0, "R10", "irq after enable cleared");

      // R8: write 0 clears
      wr(1'b1, 4'h0);
      check(req0, 1'b0, "R8", "clear by write 0");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule